// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank with Pulse-Width Output

This block holds a bank of identical down-counters, eight by default, behind a simple memory-mapped read/write port. Each channel has its own reload value, a second reload value used for the high half of a waveform, a control word and an event flag. A channel counts down once per clock while it is enabled. When it reaches zero it raises its event flag. It then either wraps around to the all-ones value or reloads from its programmed values, depending on the selected mode.

In waveform mode a channel drives a square wave on its own output pin. The low half lasts one clock longer than the first reload value, and the high half lasts one clock longer than the second reload value. Event flags can be masked per channel. They are cleared by reading a per-channel acknowledge address, or all at once by reading a shared acknowledge address. A single interrupt line is the OR of all unmasked flags.

Top module: `tmr_bank`

## Requirements
- R1: After reset every load, second-load, control and counter register reads 0, all event flags are clear, `pwm_o` and `irq_o` are low, and address 0xAC reads the `VERSION` parameter.
- R2: For channel n, the first load value is at byte address 20·n and the second load value is at 0xB0+4·n. The control word is at 20·n+8, with bit 0 = run, bit 1 = reload mode (1) or wrap mode (0), bit 2 = flag mask, bit 3 = waveform enable. Control reads return only those four bits; load registers read back what was written.
- R3: A control write that sets the run bit while it was clear copies the first load value into the counter (readable at 20·n+4) on that clock edge. The counter then decreases by one on every following edge while running.
- R4: In reload mode without waveform, a counter that is at zero is reloaded from the first load value on the next edge.
- R5: In wrap mode a counter that is at zero goes to 0xFFFFFFFF on the next edge.
- R6: With bits 0, 1 and 3 set (control 0xB), the output starts low when the run bit is set. It stays low for load+1 clocks, then high for load2+1 clocks, and then repeats.
- R7: A running counter at zero sets its raw flag, shown at bit n of 0xA8, whether masked or not. The per-channel status at 20·n+16 reads 1 only when the flag is set and bit 2 is clear.
- R8: A read of 20·n+12 clears only channel n's flag. A read of 0xA4 clears every flag. A flag being set in the same cycle wins over the clear.
- R9: Address 0xA0 bit n equals channel n's masked status, and `irq_o` is high exactly when any bit of it is set.
- R10: While the run bit is clear, the counter holds its value, the output stays low and no flag is set. Setting the run bit again reloads the counter.
- R11: Writes to counter, status, acknowledge and global status addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read strobe; gives acknowledge addresses their clearing effect |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_o | output | NCH | Waveform output per channel |
| irq_o | output | 1 | OR of all unmasked flags |

## Verification
The counters are exercised in reload mode, in wrap mode across the zero boundary, and in waveform mode with both directed and random load pairs. Together these show whether the right load register feeds each phase and whether the count is off by one. Waveform widths are measured with zero loads and with unequal low and high values, which catches swapped phases or a missing +1. Flags are driven with the mask set and cleared, and then cleared one channel at a time and all together. This separates raw, masked and combined views, and the per-channel acknowledge from the shared one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TW = 32;

  localparam int unsigned OFS_LD1  = 0;
  localparam int unsigned OFS_CNT  = 4;
  localparam int unsigned OFS_CTRL = 8;
  localparam int unsigned OFS_ACK  = 12;
  localparam int unsigned OFS_STS  = 16;

  localparam int unsigned CTRL_BITS = 4;

  typedef struct packed {
    logic wave;
    logic mask;
    logic reload;
    logic run;
  } ctrl_t;

  function automatic logic [TW-1:0] next_count(input logic [TW-1:0] cur,
                                               input ctrl_t c,
                                               input logic phase_hi,
                                               input logic [TW-1:0] ld1,
                                               input logic [TW-1:0] ld2);
    if (cur != '0) return cur - 1'b1;
    if (!c.reload) return '1;
    if (c.wave && !phase_hi) return ld2;
    return ld1;
  endfunction
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode import tmr_pkg::*; #(
  parameter int unsigned NCH      = 8,
  parameter int unsigned AW       = 8,
  parameter int unsigned STRIDE   = 20,
  parameter int unsigned ACK_ALL  = 'hA4,
  parameter int unsigned LD2_BASE = 'hB0
) (
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  output logic [NCH-1:0] wr_ld1,
  output logic [NCH-1:0] wr_ld2,
  output logic [NCH-1:0] wr_ctrl,
  output logic [NCH-1:0] ack_rd,
  output logic           ack_all_rd
);
  for (genvar g = 0; g < NCH; g++) begin : g_dec
    localparam int unsigned BASE = g * STRIDE;
    assign wr_ld1[g]  = wr_en && (addr == AW'(BASE + OFS_LD1));
    assign wr_ctrl[g] = wr_en && (addr == AW'(BASE + OFS_CTRL));
    assign wr_ld2[g]  = wr_en && (addr == AW'(LD2_BASE + 4 * g));
    assign ack_rd[g]  = rd_en && (addr == AW'(BASE + OFS_ACK));
  end
  assign ack_all_rd = rd_en && (addr == AW'(ACK_ALL));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ld1,
  input  logic          wr_ld2,
  input  logic          wr_ctrl,
  input  logic [TW-1:0] wdata,
  input  logic          clr,
  output logic [TW-1:0] cnt_o,
  output logic [TW-1:0] ld1_o,
  output logic [TW-1:0] ld2_o,
  output ctrl_t         ctrl_o,
  output logic          raw_o,
  output logic          zero_o,
  output logic          start_o,
  output logic          pwm_o
);
  logic [TW-1:0] cnt_q, ld1_q, ld2_q;
  ctrl_t         ctrl_q;
  logic          phase_q, raw_q;

  assign start_o = wr_ctrl && wdata[0] && !ctrl_q.run;
  assign zero_o  = ctrl_q.run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ld1_q   <= '0;
      ld2_q   <= '0;
      ctrl_q  <= '0;
      phase_q <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      if (wr_ld1)  ld1_q  <= wdata;
      if (wr_ld2)  ld2_q  <= wdata;
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[CTRL_BITS-1:0]);
      if (start_o) begin
        cnt_q   <= ld1_q;
        phase_q <= 1'b0;
      end else if (ctrl_q.run) begin
        cnt_q <= next_count(cnt_q, ctrl_q, phase_q, ld1_q, ld2_q);
        if (zero_o && ctrl_q.wave) phase_q <= !phase_q;
      end
      if (zero_o)   raw_q <= 1'b1;
      else if (clr) raw_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign ld1_o  = ld1_q;
  assign ld2_o  = ld2_q;
  assign ctrl_o = ctrl_q;
  assign raw_o  = raw_q;
  assign pwm_o  = ctrl_q.run && ctrl_q.wave && phase_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank import tmr_pkg::*; #(
  parameter int unsigned    NCH     = 8,
  parameter int unsigned    AW      = 8,
  parameter logic [TW-1:0]  VERSION = 32'h0001_0200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [TW-1:0]  wdata,
  output logic [TW-1:0]  rdata,
  output logic [NCH-1:0] pwm_o,
  output logic           irq_o
);
  localparam int unsigned STRIDE   = 20;
  localparam int unsigned STS_ALL  = 'hA0;
  localparam int unsigned ACK_ALL  = 'hA4;
  localparam int unsigned RAW_ALL  = 'hA8;
  localparam int unsigned VER_ADR  = 'hAC;
  localparam int unsigned LD2_BASE = 'hB0;

  logic [NCH-1:0]         wr_ld1, wr_ld2, wr_ctrl, ack_rd;
  logic                   ceoi_rd;
  logic [NCH-1:0][TW-1:0] cnt_w, ld1_w, ld2_w;
  ctrl_t [NCH-1:0]        ctrl_w;
  logic [NCH-1:0]         raw_w, zero_w, start_w, mask_w, sts_w;

  tmr_decode #(.NCH(NCH), .AW(AW), .STRIDE(STRIDE), .ACK_ALL(ACK_ALL),
               .LD2_BASE(LD2_BASE)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_ld1(wr_ld1), .wr_ld2(wr_ld2), .wr_ctrl(wr_ctrl),
    .ack_rd(ack_rd), .ack_all_rd(ceoi_rd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_channel u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_ld1(wr_ld1[g]), .wr_ld2(wr_ld2[g]), .wr_ctrl(wr_ctrl[g]),
      .wdata(wdata), .clr(ack_rd[g] | ceoi_rd),
      .cnt_o(cnt_w[g]), .ld1_o(ld1_w[g]), .ld2_o(ld2_w[g]),
      .ctrl_o(ctrl_w[g]), .raw_o(raw_w[g]), .zero_o(zero_w[g]),
      .start_o(start_w[g]), .pwm_o(pwm_o[g])
    );
    assign mask_w[g] = ctrl_w[g].mask;
  end

  assign sts_w = raw_w & ~mask_w;
  assign irq_o = |sts_w;

  always_comb begin
    rdata = '0;
    for (int n = 0; n < NCH; n++) begin
      if (addr == AW'(n * STRIDE + OFS_LD1))  rdata = ld1_w[n];
      if (addr == AW'(n * STRIDE + OFS_CNT))  rdata = cnt_w[n];
      if (addr == AW'(n * STRIDE + OFS_CTRL)) rdata = TW'(ctrl_w[n]);
      if (addr == AW'(n * STRIDE + OFS_STS))  rdata = TW'(sts_w[n]);
      if (addr == AW'(LD2_BASE + 4 * n))      rdata = ld2_w[n];
    end
    if (addr == AW'(STS_ALL)) rdata = TW'(sts_w);
    if (addr == AW'(RAW_ALL)) rdata = TW'(raw_w);
    if (addr == AW'(VER_ADR)) rdata = VERSION;
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk import tmr_pkg::*; #(
  parameter int unsigned NCH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         pwm_o,
  input logic                   irq_o,
  input logic [NCH-1:0][TW-1:0] cnt_w,
  input logic [NCH-1:0][TW-1:0] ld1_w,
  input ctrl_t [NCH-1:0]        ctrl_w,
  input logic [NCH-1:0]         raw_w,
  input logic [NCH-1:0]         zero_w,
  input logic [NCH-1:0]         start_w,
  input logic                   ceoi_rd
);
  logic [NCH-1:0] unmasked;
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assign unmasked[g] = raw_w[g] && !ctrl_w[g].mask;

    p_load_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_w[g] |=> cnt_w[g] == $past(ld1_w[g]));
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_w[g].run && cnt_w[g] != '0) |=> cnt_w[g] == $past(cnt_w[g]) - 1'b1);
    p_free_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_w[g] && !ctrl_w[g].reload) |=> cnt_w[g] == '1);
    p_start_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_w[g] |=> !pwm_o[g]);
    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      zero_w[g] |=> raw_w[g]);
    p_ack_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ceoi_rd && !zero_w[g]) |=> !raw_w[g]);
    p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_w[g].run && !start_w[g]) |=> $stable(cnt_w[g]));
  end

  p_irq_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (unmasked != '0));
endmodule

bind tmr_bank tmr_bank_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_o(pwm_o), .irq_o(irq_o),
  .cnt_w(cnt_w), .ld1_w(ld1_w), .ctrl_w(ctrl_w), .raw_w(raw_w),
  .zero_w(zero_w), .start_w(start_w), .ceoi_rd(ceoi_rd)
);

// File: tb/test_tmr_bank.sv
module test_tmr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pwm_o;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  tmr_bank i_tmr_bank (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o), .irq_o(irq_o));

  always #10 clk = !clk;

  function automatic logic [7:0] a_ld1(input int c);  return 8'(c * 20);      endfunction
  function automatic logic [7:0] a_cnt(input int c);  return 8'(c * 20 + 4);  endfunction
  function automatic logic [7:0] a_ctl(input int c);  return 8'(c * 20 + 8);  endfunction
  function automatic logic [7:0] a_ack(input int c);  return 8'(c * 20 + 12); endfunction
  function automatic logic [7:0] a_sts(input int c);  return 8'(c * 20 + 16); endfunction
  function automatic logic [7:0] a_ld2(input int c);  return 8'('hB0 + 4 * c); endfunction
  function automatic int phase_len(input int ld);     return ld + 1;          endfunction
  function automatic logic [31:0] wrap_dec(input logic [31:0] v);
    return (v == 0) ? 32'hFFFF_FFFF : v - 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1; addr = a;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 0;
  endtask

  task automatic measure(input int c, output int lo, output int hi, output int lo2);
    lo = 0; hi = 0; lo2 = 0;
    while (!pwm_o[c] && lo < 2000)  begin lo++;  @(negedge clk); end
    while (pwm_o[c] && hi < 2000)   begin hi++;  @(negedge clk); end
    while (!pwm_o[c] && lo2 < 2000) begin lo2++; @(negedge clk); end
  endtask

  task automatic run_wave(input int c, input int l, input int h, input string tag);
    int lo, hi, lo2;
    wr(a_ld1(c), 32'(l));
    wr(a_ld2(c), 32'(h));
    wr(a_ctl(c), 32'hB);
    measure(c, lo, hi, lo2);
    check({tag, " R6 low"},  32'(lo),  32'(phase_len(l)));
    check({tag, " R6 high"}, 32'(hi),  32'(phase_len(h)));
    check({tag, " R6 low2"}, 32'(lo2), 32'(phase_len(l)));
    wr(a_ctl(c), 32'h0);
    check({tag, " R10 out low"}, 32'(pwm_o[c]), 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, e, v1, v2;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(a_ctl(0), d);  check("R1 ctrl0", d, 0);
    rd(a_cnt(3), d);  check("R1 cnt3", d, 0);
    rd(a_ld2(7), d);  check("R1 ld2_7", d, 0);
    rd(8'hA8, d);     check("R1 raw", d, 0);
    rd(8'hAC, d);     check("R1 version", d, 32'h0001_0200);
    check("R1 pwm", 32'(pwm_o), 0);
    check("R1 irq", 32'(irq_o), 0);

    // R2 register map readback
    for (int c = 0; c < 8; c++) begin
      v1 = $urandom; v2 = $urandom;
      wr(a_ld1(c), v1); wr(a_ld2(c), v2); wr(a_ctl(c), 32'hFFFF_FFF4);
      rd(a_ld1(c), d); check("R2 ld1", d, v1);
      rd(a_ld2(c), d); check("R2 ld2", d, v2);
      rd(a_ctl(c), d); check("R2 ctrl", d, 32'h4);
      wr(a_ctl(c), 0);
    end

    // R3 start and count down
    wr(a_ld1(2), 5); wr(a_ctl(2), 3);
    e = 5;
    for (int k = 0; k < 3; k++) begin
      rd(a_cnt(2), d); check("R3 countdown", d, e); e = e - 1;
    end
    wr(a_ctl(2), 0);            // steps once more as it stops
    rd(a_cnt(2), d); check("R10 frozen", d, 1);
    rd(a_cnt(2), d); check("R10 frozen again", d, 1);
    // R11 writes to read-only addresses
    wr(a_cnt(2), 32'h1234);
    wr(a_sts(2), 32'h1);
    wr(8'hA8, 32'hFF);
    rd(a_cnt(2), d); check("R11 cnt write ignored", d, 1);
    rd(a_ld1(2), d); check("R11 ld1 unchanged", d, 5);

    // R4 reload mode
    wr(a_ld1(2), 2); wr(a_ctl(2), 3);
    e = 2;
    for (int k = 0; k < 6; k++) begin
      rd(a_cnt(2), d); check("R4 reload", d, e);
      e = (e == 0) ? 2 : e - 1;
    end
    wr(a_ctl(2), 0);

    // R5 wrap mode
    wr(a_ld1(4), 3); wr(a_ctl(4), 1);
    e = 3;
    for (int k = 0; k < 6; k++) begin
      rd(a_cnt(4), d); check("R5 wrap", d, e); e = wrap_dec(e);
    end
    wr(a_ctl(4), 0);

    // R8 clear all
    rd(8'hA4, d);
    rd(8'hA8, d); check("R8 ack all", d, 0);

    // R7 masked flag
    wr(a_ld1(1), 1); wr(a_ctl(1), 7);
    repeat (4) @(negedge clk);
    wr(a_ctl(1), 4);
    rd(8'hA8, d);    check("R7 raw set", d, 32'h2);
    rd(a_sts(1), d); check("R7 masked status", d, 0);
    rd(8'hA0, d);    check("R9 combined masked", d, 0);
    check("R9 irq masked", 32'(irq_o), 0);
    wr(a_ctl(1), 0);
    rd(a_sts(1), d); check("R7 unmasked status", d, 1);
    rd(8'hA0, d);    check("R9 combined", d, 32'h2);
    check("R9 irq", 32'(irq_o), 1);

    // R8 single and shared acknowledge
    wr(a_ld1(6), 0); wr(a_ctl(6), 3); wr(a_ctl(6), 0);
    rd(8'hA8, d);    check("R8 two flags", d, 32'h42);
    rd(a_ack(1), d);
    rd(8'hA8, d);    check("R8 single ack", d, 32'h40);
    rd(8'hA4, d);
    rd(8'hA8, d);    check("R8 shared ack", d, 0);
    check("R9 irq clear", 32'(irq_o), 0);

    // R6 waveform, directed and random
    run_wave(0, 3, 5, "dir");
    run_wave(5, 0, 0, "zero");
    run_wave(7, 9, 1, "skew");
    for (int k = 0; k < 6; k++)
      run_wave(int'($urandom % 8), int'($urandom % 16), int'($urandom % 16), "rnd");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule